// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Front End with Banked Index Latches

This block connects a host's multiplexed 8-bit address/data bus to a peripheral's register file, all on one fast system clock. An address strobe carries an index into one of two 7-bit index latches. A bank-select pin picks the latch, both when the address is taken and again during the data phase. A static mode pin selects one of two bus styles. In the first style, a data strobe and a direction pin define the transfer. In the second style, there is a separate active-low read strobe and a separate active-low write strobe. Each completed transfer leaves the block as a one-cycle read or write strobe that carries a bank bit and a 7-bit offset.

The block keeps two read-only shadow registers. Each holds the last index used in its own bank. The host reads them in the extended bank at offsets 7Eh and 7Fh. The top bit of each comes from an external status input. A RAM-clear pin that is held low long enough produces a single clear pulse for the storage and sets both shadows to zero.

The register-file port is a plain strobe interface with no back-pressure. The register file must accept every write strobe in the cycle it is asserted. It returns read data combinationally for the offset and bank on the port.

Top module: `mbus_front`

## Requirements
- R1: A falling edge on `as` loads `ad_in[6:0]` into the standard index latch if `bank_sel` is 0, or into the extended index latch if it is 1. This happens even when `cs_n` is high.
- R2: During the data phase, the current `bank_sel` level picks which latch supplies `rf_off`. The same level appears on `rf_bank`.
- R3: With `bus_mode`=1, a write happens on a falling edge of `ds` while `rw`=0, with the data taken from `ad_in` at that edge. A read happens on a rising edge of `ds` while `rw`=1.
- R4: With `bus_mode`=0, `ds` is an active-low read strobe and a read happens on its falling edge. `rw` is an active-low write strobe and a write happens on its rising edge.
- R5: A strobe edge seen while `cs_n` is high causes no `rf_rd`, no `rf_wr` and no shadow update.
- R6: `ad_oe` is high only during a read data phase with `cs_n` low. The read phase is `ds`=1 with `rw`=1 in mode 1, and `ds`=0 in mode 0. While `ad_oe` is high, `ad_out` holds the byte read at the current offset.
- R7: In the extended bank, offset 7Eh reads as {`nmi_bit`, standard shadow} and offset 7Fh reads as {`cent_bit`, extended shadow}. Accesses to these two offsets raise no `rf_rd` or `rf_wr`, and writes to them change nothing.
- R8: Each completed access outside 7Eh/7Fh of the extended bank loads its offset into the shadow register of its bank.
- R9: `clr_n` held low for `CLR_CYCLES` consecutive synchronized cycles gives exactly one `mem_clear` pulse and zeroes both shadows. A shorter low pulse has no effect.
- R10: `rf_rd`, `rf_wr` and `mem_clear` are single-cycle pulses, and `rf_rd` and `rf_wr` are never high together. While `rst_n` is low, bus activity produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Static bus style: 1 = strobe plus direction, 0 = separate read/write strobes |
| cs_n | input | 1 | Active-low chip select for the data phase |
| as | input | 1 | Address strobe; its falling edge captures the index |
| ds | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw | input | 1 | Direction, 1 = read (mode 1), or active-low write strobe (mode 0) |
| bank_sel | input | 1 | Bank select, used at address capture and at data transfer |
| ad_in | input | 8 | Bus value seen at the pins |
| ad_out | output | 8 | Read data for the bus drivers |
| ad_oe | output | 1 | Bus driver enable |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_bank | output | 1 | Bank of the access |
| rf_off | output | 7 | Offset of the access |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data for `rf_bank`/`rf_off` |
| nmi_bit | input | 1 | Top bit shown in the 7Eh shadow |
| cent_bit | input | 1 | Top bit shown in the 7Fh shadow |
| clr_n | input | 1 | Active-low RAM-clear request |
| mem_clear | output | 1 | One-cycle storage clear pulse |

## Verification
The assertions check on every cycle that the read and write strobes never overlap and that each strobe lasts one cycle. They also check that the driver enable follows a low chip select by exactly the synchronizer delay, that no write ever targets a shadow offset, and that the shadows are zero whenever the clear pulse is out. Only the bench scenarios can show the rest. These are the offset and data values carried through each bus style, the bank steering when the two latches hold different indices, the values read back from the shadows, and the difference between a short and a long clear request.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 7;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [IDX_W-1:0]  idx_t;
  // extended-bank offsets that mirror the last indices
  localparam idx_t SHD_STD_OFF = idx_t'(7'h7E);
  localparam idx_t SHD_EXT_OFF = idx_t'(7'h7F);
endpackage

// File: rtl/mbf_sync.sv
module mbf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mbf_strobe_decode.sv
module mbf_strobe_decode (
  input  logic mode,
  input  logic cs_s,
  input  logic ds_s,
  input  logic ds_p,
  input  logic rw_s,
  input  logic rw_p,
  output logic rd_go,
  output logic wr_go,
  output logic rd_phase
);
  always_comb begin
    if (mode) begin
      rd_go    = !cs_s && ds_s && !ds_p && rw_s;
      wr_go    = !cs_s && !ds_s && ds_p && !rw_s;
      rd_phase = !cs_s && ds_s && rw_s;
    end else begin
      rd_go    = !cs_s && !ds_s && ds_p;
      wr_go    = !cs_s && rw_s && !rw_p;
      rd_phase = !cs_s && !ds_s;
    end
  end
endmodule

// File: rtl/mbf_clear_debounce.sv
module mbf_clear_debounce #(
  parameter int CLR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  output logic fire
);
  localparam int CNT_W = $clog2(CLR_CYCLES + 1);
  logic             clr_s;
  logic [CNT_W-1:0] cnt;

  mbf_sync #(.W(1), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(clr_n), .q(clr_s)
  );

  assign fire = !clr_s && (cnt == CNT_W'(CLR_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt <= '0;
    else if (clr_s)                         cnt <= '0;
    else if (cnt != CNT_W'(CLR_CYCLES))     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mbus_front.sv
module mbus_front
  import mbf_pkg::*;
#(
  parameter int CLR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_mode,
  input  logic              cs_n,
  input  logic              as,
  input  logic              ds,
  input  logic              rw,
  input  logic              bank_sel,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic              rf_bank,
  output logic [IDX_W-1:0]  rf_off,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  input  logic              nmi_bit,
  input  logic              cent_bit,
  input  logic              clr_n,
  output logic              mem_clear
);
  localparam int SW = 5 + DATA_W;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {DATA_W{1'b0}}};

  logic [SW-1:0] pins_s;
  logic  as_s, ds_s, rw_s, cs_s, bank_s;
  byte_t ad_s;
  logic  as_p, ds_p, rw_p;
  logic  rd_go, wr_go, rd_phase, clr_fire;
  idx_t  idx_std, idx_ext, shd_std, shd_ext, cur_off;
  logic  cur_shd, rd_q, rd_shd_q, rd_sel_q;

  mbf_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({as, ds, rw, cs_n, bank_sel, ad_in}),
    .q(pins_s)
  );
  assign {as_s, ds_s, rw_s, cs_s, bank_s, ad_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_p <= 1'b0;
      ds_p <= 1'b0;
      rw_p <= 1'b1;
    end else begin
      as_p <= as_s;
      ds_p <= ds_s;
      rw_p <= rw_s;
    end
  end

  mbf_strobe_decode i_decode (
    .mode(bus_mode), .cs_s(cs_s), .ds_s(ds_s), .ds_p(ds_p),
    .rw_s(rw_s), .rw_p(rw_p),
    .rd_go(rd_go), .wr_go(wr_go), .rd_phase(rd_phase)
  );

  mbf_clear_debounce #(.CLR_CYCLES(CLR_CYCLES)) i_clear (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .fire(clr_fire)
  );

  // index capture on address strobe fall, independent of chip select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_std <= '0;
      idx_ext <= '0;
    end else if (as_p && !as_s) begin
      if (bank_s) idx_ext <= ad_s[IDX_W-1:0];
      else        idx_std <= ad_s[IDX_W-1:0];
    end
  end

  assign cur_off = bank_s ? idx_ext : idx_std;
  assign cur_shd = bank_s && (cur_off == SHD_STD_OFF || cur_off == SHD_EXT_OFF);

  // shadows of the last index used per bank; clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_std <= '0;
      shd_ext <= '0;
    end else if (clr_fire) begin
      shd_std <= '0;
      shd_ext <= '0;
    end else if ((rd_go || wr_go) && !cur_shd) begin
      if (bank_s) shd_ext <= cur_off;
      else        shd_std <= cur_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_rd     <= 1'b0;
      rf_wr     <= 1'b0;
      rf_bank   <= 1'b0;
      rf_off    <= '0;
      rf_wdata  <= '0;
      rd_q      <= 1'b0;
      rd_shd_q  <= 1'b0;
      rd_sel_q  <= 1'b0;
      ad_oe     <= 1'b0;
      ad_out    <= '0;
      mem_clear <= 1'b0;
    end else begin
      rf_rd     <= rd_go && !cur_shd;
      rf_wr     <= wr_go && !cur_shd;
      rd_q      <= rd_go;
      ad_oe     <= rd_phase;
      mem_clear <= clr_fire;
      if (rd_go || wr_go) begin
        rf_bank  <= bank_s;
        rf_off   <= cur_off;
        rd_shd_q <= cur_shd;
        rd_sel_q <= cur_off[0];
      end
      if (wr_go) rf_wdata <= ad_s;
      if (rd_q) begin
        if (!rd_shd_q)     ad_out <= rf_rdata;
        else if (rd_sel_q) ad_out <= {cent_bit, shd_ext};
        else               ad_out <= {nmi_bit, shd_std};
      end
    end
  end
endmodule

// File: rtl/mbf_checker.sv
module mbf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ad_oe,
  input logic       rf_rd,
  input logic       rf_wr,
  input logic       rf_bank,
  input logic [6:0] rf_off,
  input logic       mem_clear,
  input logic [6:0] shd_std,
  input logic [6:0] shd_ext
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_rd && rf_wr)); // R10
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |=> !rf_rd); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> !rf_wr); // R10
  AST_OE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !$past(cs_n, 3)); // R6
  AST_NO_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> !(rf_bank && rf_off[6:1] == 6'h3F)); // R7
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |-> (shd_std == 7'd0 && shd_ext == 7'd0)); // R9
  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clear |=> !mem_clear); // R9
endmodule

bind mbus_front mbf_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ad_oe(ad_oe),
  .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_bank(rf_bank), .rf_off(rf_off),
  .mem_clear(mem_clear), .shd_std(shd_std), .shd_ext(shd_ext)
);

// File: tb/test_mbus_front.sv
`timescale 1ns/1ps
module test_mbus_front;
  localparam int CLR = 20;

  logic clk = 0, rst_n = 0, bus_mode = 1, cs_n = 1, as = 0, ds = 0, rw = 1, bank_sel = 0;
  logic nmi_bit = 1, cent_bit = 0, clr_n = 1;
  logic host_drive = 0;
  logic [7:0] host_val = 0;
  wire  [7:0] ad_bus;
  logic [7:0] ad_out, rf_wdata, rf_rdata;
  logic ad_oe, rf_rd, rf_wr, rf_bank, mem_clear;
  logic [6:0] rf_off;
  logic [7:0] mem [0:255];
  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0, clr_cnt = 0;
  logic [6:0] last_off;
  logic last_bank;
  logic [7:0] last_data;

  always #4 clk = ~clk;

  assign ad_bus = ad_oe ? ad_out : 8'hzz;
  assign ad_bus = host_drive ? host_val : 8'hzz;
  assign rf_rdata = mem[{rf_bank, rf_off}];

  mbus_front #(.CLR_CYCLES(CLR)) i_mbus_front (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .as(as), .ds(ds),
    .rw(rw), .bank_sel(bank_sel), .ad_in(ad_bus), .ad_out(ad_out), .ad_oe(ad_oe),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_bank(rf_bank), .rf_off(rf_off),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .nmi_bit(nmi_bit), .cent_bit(cent_bit),
    .clr_n(clr_n), .mem_clear(mem_clear)
  );

  always @(posedge clk) begin
    if (rf_wr) begin
      wr_cnt <= wr_cnt + 1;
      last_off <= rf_off; last_bank <= rf_bank; last_data <= rf_wdata;
      mem[{rf_bank, rf_off}] <= rf_wdata;
    end
    if (rf_rd) rd_cnt <= rd_cnt + 1;
    if (mem_clear) clr_cnt <= clr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int m, input int b, input int o);
    return 8'((o * 7 + b * 8'h5A + m * 8'h33) & 8'hFF);
  endfunction

  task automatic addr_phase(input logic b, input logic [6:0] a);
    bank_sel = b; host_val = {1'b0, a}; host_drive = 1; as = 1; cyc(3);
    as = 0; cyc(3); host_drive = 0;
  endtask

  task automatic data_write(input logic b, input logic [7:0] d, input logic sel);
    bank_sel = b; host_val = d; host_drive = 1; cs_n = !sel;
    if (bus_mode) begin
      rw = 0; cyc(2); ds = 1; cyc(4); ds = 0; cyc(4); rw = 1;
    end else begin
      cyc(2); rw = 0; cyc(4); rw = 1; cyc(4);
    end
    cs_n = 1; host_drive = 0; cyc(3);
  endtask

  task automatic data_read(input logic b, input logic sel, output logic [7:0] d, output logic oe);
    bank_sel = b; cs_n = !sel;
    if (bus_mode) begin
      rw = 1; cyc(2); ds = 1; cyc(6); d = ad_bus; oe = ad_oe; ds = 0;
    end else begin
      cyc(2); ds = 0; cyc(6); d = ad_bus; oe = ad_oe; ds = 1;
    end
    cyc(4); cs_n = 1; cyc(3);
  endtask

  task automatic restart(input logic m);
    rst_n = 0; bus_mode = m; ds = !m; rw = 1; cs_n = 1; as = 0; cyc(4);
    rst_n = 1; cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int w0, r0;
    cyc(4);
    rst_n = 1; cyc(4);
    chk(!ad_oe && !rf_rd && !rf_wr && !mem_clear, "R10 reset state",
        {ad_oe, rf_rd, rf_wr, mem_clear}, 0);

    for (int m = 1; m >= 0; m--) begin
      restart(1'(m));
      // write sweep; address phases run with cs_n high (R1)
      for (int b = 0; b < 2; b++)
        for (int o = 0; o < 128; o++) begin
          if (b == 1 && o >= 126) continue;
          w0 = wr_cnt;
          addr_phase(1'(b), 7'(o));
          data_write(1'(b), pat(m, b, o), 1);
          chk(wr_cnt == w0 + 1 && last_off == 7'(o) && last_bank == 1'(b) &&
              last_data == pat(m, b, o), m ? "R3 R1 write" : "R4 R1 write",
              {last_bank, last_off, last_data}, {b[0], 7'(o), pat(m, b, o)});
        end
      // read sweep
      for (int b = 0; b < 2; b++)
        for (int o = 0; o < 128; o++) begin
          if (b == 1 && o >= 126) continue;
          r0 = rd_cnt;
          addr_phase(1'(b), 7'(o));
          data_read(1'(b), 1, d, oe);
          chk(d == pat(m, b, o) && oe && rd_cnt == r0 + 1,
              m ? "R3 R6 read" : "R4 R6 read", {oe, d}, {1'b1, pat(m, b, o)});
          chk(!ad_oe, "R6 oe released", ad_oe, 0);
        end
      // R5: no access without chip select
      w0 = wr_cnt; r0 = rd_cnt;
      addr_phase(0, 7'h05);
      data_write(0, 8'hEE, 0);
      data_read(0, 0, d, oe);
      chk(wr_cnt == w0 && rd_cnt == r0 && !oe, "R5 cs high", wr_cnt - w0, 0);
      data_read(0, 1, d, oe);
      chk(d == pat(m, 0, 5), "R5 data kept", d, pat(m, 0, 5));
    end

    // R2: bank steering with both latches loaded
    addr_phase(0, 7'h11);
    addr_phase(1, 7'h22);
    data_write(1, 8'hA1, 1);
    chk(last_off == 7'h22 && last_bank, "R2 ext latch", {last_bank, last_off}, {1'b1, 7'h22});
    data_write(0, 8'hB2, 1);
    chk(last_off == 7'h11 && !last_bank, "R2 std latch", {last_bank, last_off}, {1'b0, 7'h11});

    // R7/R8: shadow reads
    r0 = rd_cnt;
    addr_phase(1, 7'h7E);
    data_read(1, 1, d, oe);
    chk(d == {1'b1, 7'h11}, "R8 R7 std shadow", d, {1'b1, 7'h11});
    addr_phase(1, 7'h7F);
    data_read(1, 1, d, oe);
    chk(d == {1'b0, 7'h22}, "R8 R7 ext shadow", d, {1'b0, 7'h22});
    chk(rd_cnt == r0, "R7 no rf_rd", rd_cnt - r0, 0);
    w0 = wr_cnt;
    nmi_bit = 0; cent_bit = 1;
    data_write(1, 8'h00, 1);
    data_read(1, 1, d, oe);
    chk(wr_cnt == w0 && d == {1'b1, 7'h22}, "R7 write ignored", d, {1'b1, 7'h22});
    addr_phase(1, 7'h7E);
    data_read(1, 1, d, oe);
    chk(d == {1'b0, 7'h11}, "R7 nmi bit", d, {1'b0, 7'h11});

    // R9: short clear ignored, long clear acts once
    clr_n = 0; cyc(CLR - 4); clr_n = 1; cyc(6);
    chk(clr_cnt == 0, "R9 short clear", clr_cnt, 0);
    data_read(1, 1, d, oe);
    chk(d == {1'b0, 7'h11}, "R9 shadow kept", d, {1'b0, 7'h11});
    clr_n = 0; cyc(CLR + 10); clr_n = 1; cyc(6);
    chk(clr_cnt == 1, "R9 one pulse", clr_cnt, 1);
    data_read(1, 1, d, oe);
    chk(d == 8'h00, "R9 std shadow zero", d, 0);
    addr_phase(1, 7'h7F);
    data_read(1, 1, d, oe);
    chk(d == 8'h80, "R9 ext shadow zero", d, 8'h80);

    // R10: accesses during reset are ignored
    rst_n = 0; w0 = wr_cnt;
    addr_phase(0, 7'h03);
    data_write(0, 8'h77, 1);
    chk(wr_cnt == w0, "R10 reset ignores", wr_cnt - w0, 0);
    rst_n = 1; cyc(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule